// File: doc/BRIEF.md
# Programmable Prescaler Timer with One-Shot Output

The block is a 16-stage binary prescaler that advances on a clock-enable pulse from an oscillator and drives one timed output, `q`. Two select inputs choose which counter stage the output follows. A set/reset output latch turns that stage into either a recycling square wave or a single transition per run. In single-cycle mode, the block works as a retriggerable one-shot: a reset pulse starts a timed interval, and the output holds its reset level until the chosen number of oscillator ticks has gone by.

A reset comes from three sources. The master reset input is one. A power-on pulse is another, and it can be blocked. A change of level on the mode input is the third. Each reset clears the whole counter and the output latch on the next clock edge. While reset is held, the output takes the level of the polarity select input. In the shortcut select code, the upper half of the chain is clocked straight from the oscillator, which shortens the timed interval by a factor of 256.

Top module: `tmr_oneshot_top`

## Requirements
- R1: Select code {sel_a,sel_b} is read with sel_a as the MSB. Code 2'b00 selects stage 13, code 2'b01 selects stage 10 and code 2'b11 selects stage 16. In single-cycle mode, `q` leaves its reset level after exactly 2^(n-1) ticks for stage n: 4096, 512 and 32768 ticks.
- R2: With code 2'b10, stage 16 is selected and stages 9 to 16 advance on every tick. A single-cycle run then lasts 128 ticks, and recycle mode gives 128 ticks at each level.
- R3: `mr`=1 at a clock edge clears the counter and the output latch at that edge, whatever the count. `q` equals `qsel` after every edge at which reset is active.
- R4: A `por_pulse` acts as a reset when `por_block`=0. The pulse has no effect on `q` or on the timing when `por_block`=1.
- R5: When `mode`=1 (recycle), `q` equals the selected stage bit XOR `qsel`. The output starts at `qsel` after reset and inverts every 2^(n-1) ticks.
- R6: When `mode`=0 (single-cycle), `q` changes once to the inverse of `qsel`. It then stays there until the next reset, even as the counter keeps running.
- R7: A master reset during a run in progress restarts the full interval. `q` returns to `qsel`, and the full 2^(n-1) ticks are counted again.
- R8: A change in the level of `mode` acts as a reset at the following clock edge.
- R9: The counter advances only at edges where `osc_tick`=1. Gaps between ticks add no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| osc_tick | input | 1 | Oscillator clock-enable, one pulse per count |
| mr | input | 1 | Master reset, active high, synchronous |
| por_block | input | 1 | 1 blocks the power-on reset request |
| por_pulse | input | 1 | Power-on reset request |
| sel_a | input | 1 | Stage select MSB |
| sel_b | input | 1 | Stage select LSB |
| qsel | input | 1 | Output level while reset; recycle polarity |
| mode | input | 1 | 1 recycle, 0 single-cycle one-shot |
| q | output | 1 | Timed output, registered |

## Verification
The hardest case to reach from the ports is a single-cycle run with a long stage. The latch must stay set after the counter wraps back past the tap. A late reset must also restart the full interval and not continue from the previous count. The stimulus covers this with tick bursts of 512 or more after the output has fallen. It also issues a master reset and a blocked power-on pulse partway through a run, and a pulse of the mode input after the output has fallen. Every clock edge is compared against a behavioural tick-count model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_MID   = 2'b00,
    SEL_LOW   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_TOP   = 2'b11
  } tap_code_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int STAGES = 16,
  parameter int SPLIT  = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              tick,
  input  logic              short_en,
  output logic [STAGES-1:0] cnt_next,
  output logic [STAGES-1:0] cnt
);
  localparam int HW = STAGES - SPLIT;

  logic [SPLIT-1:0] lo_n;
  logic [HW-1:0]    hi_n;
  logic             carry;
  logic             hi_inc;

  always_comb begin
    carry    = tick & (&cnt[SPLIT-1:0]);
    hi_inc   = short_en ? tick : carry;
    lo_n     = cnt[SPLIT-1:0] + {{(SPLIT-1){1'b0}}, tick};
    hi_n     = cnt[STAGES-1:SPLIT] + {{(HW-1){1'b0}}, hi_inc};
    cnt_next = clr ? '0 : {hi_n, lo_n};
  end

  always_ff @(posedge clk) begin
    cnt <= cnt_next;
  end

  // R9: no tick, no count change
  a_r9_hold: assert property (@(posedge clk) disable iff (clr)
    !tick |=> cnt == $past(cnt));

  // R2: in shortcut mode the upper stages step on every tick
  a_r2_short_step: assert property (@(posedge clk) disable iff (clr)
    (tick && short_en) |=> cnt[STAGES-1:SPLIT] == $past(cnt[STAGES-1:SPLIT]) + 1'b1);
endmodule

// File: rtl/tmr_tap_sel.sv
module tmr_tap_sel
  import tmr_pkg::*;
#(
  parameter int STAGES  = 16,
  parameter int TAP_MID = 13,
  parameter int TAP_LOW = 10,
  parameter int TAP_TOP = 16
) (
  input  logic [STAGES-1:0] cnt_next,
  input  logic              sel_a,
  input  logic              sel_b,
  output logic              tap_bit,
  output logic              short_en
);
  tap_code_e code;

  always_comb begin
    code     = tap_code_e'({sel_a, sel_b});
    short_en = (code == SEL_SHORT);
    unique case (code)
      SEL_MID: tap_bit = cnt_next[TAP_MID-1];
      SEL_LOW: tap_bit = cnt_next[TAP_LOW-1];
      default: tap_bit = cnt_next[TAP_TOP-1];
    endcase
  end
endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage (
  input  logic clk,
  input  logic clr,
  input  logic mode,
  input  logic qsel,
  input  logic tap_bit,
  output logic q
);
  logic latch;
  logic latch_n;

  always_comb begin
    latch_n = clr ? 1'b0 : (latch | (tap_bit & ~mode));
  end

  always_ff @(posedge clk) begin
    latch <= latch_n;
    if (clr)
      q <= qsel;
    else
      q <= qsel ^ (mode ? tap_bit : latch_n);
  end

  // R6: once set in single-cycle mode the latch holds until reset
  a_r6_sticky: assert property (@(posedge clk) disable iff (clr)
    (!mode && latch) |=> latch);

  // R6: a set latch in steady single-cycle mode shows as inverted output
  a_r6_q_inverted: assert property (@(posedge clk) disable iff (clr)
    (!mode && latch && $stable(qsel)) |=> q == ~$past(qsel));
endmodule

// File: rtl/tmr_oneshot_top.sv
module tmr_oneshot_top #(
  parameter int STAGES  = 16,
  parameter int SPLIT   = 8,
  parameter int TAP_MID = 13,
  parameter int TAP_LOW = 10,
  parameter int TAP_TOP = 16
) (
  input  logic clk,
  input  logic osc_tick,
  input  logic mr,
  input  logic por_block,
  input  logic por_pulse,
  input  logic sel_a,
  input  logic sel_b,
  input  logic qsel,
  input  logic mode,
  output logic q
);
  logic              mode_d;
  logic              mode_chg;
  logic              por_clr;
  logic              clr;
  logic              short_en;
  logic              tap_bit;
  logic [STAGES-1:0] cnt_next;
  logic [STAGES-1:0] cnt;

  always_ff @(posedge clk) begin
    mode_d <= mode;
  end

  always_comb begin
    mode_chg = mode ^ mode_d;
    por_clr  = por_pulse & ~por_block;
    clr      = mr | por_clr | mode_chg;
  end

  tmr_prescaler #(.STAGES(STAGES), .SPLIT(SPLIT)) u_cnt (
    .clk      (clk),
    .clr      (clr),
    .tick     (osc_tick),
    .short_en (short_en),
    .cnt_next (cnt_next),
    .cnt      (cnt)
  );

  tmr_tap_sel #(.STAGES(STAGES), .TAP_MID(TAP_MID), .TAP_LOW(TAP_LOW),
                .TAP_TOP(TAP_TOP)) u_sel (
    .cnt_next (cnt_next),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .tap_bit  (tap_bit),
    .short_en (short_en)
  );

  tmr_out_stage u_out (
    .clk     (clk),
    .clr     (clr),
    .mode    (mode),
    .qsel    (qsel),
    .tap_bit (tap_bit),
    .q       (q)
  );

  // R3: master reset clears the count and loads qsel onto q
  a_r3_mr_clears: assert property (@(posedge clk) disable iff (por_clr)
    mr |=> (cnt == '0) && (q == $past(qsel)));

  // R8: a mode level change clears the count at the next edge
  a_r8_mode_clear: assert property (@(posedge clk) disable iff (mr)
    mode_chg |=> cnt == '0);
endmodule

// File: tb/tb_tmr_oneshot_top.sv
module tb_tmr_oneshot_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic osc_tick = 1'b0, mr = 1'b1, por_block = 1'b1, por_pulse = 1'b0;
  logic sel_a = 1'b0, sel_b = 1'b1, qsel = 1'b1, mode = 1'b0;
  logic q;

  int errors = 0;
  int checks = 0;
  bit armed  = 1'b0;
  bit done   = 1'b0;

  // behavioural model state
  int  m_lo = 0, m_hi = 0;
  bit  m_latch = 0, m_q = 0, m_mode_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_oneshot_top dut (
    .clk(clk), .osc_tick(osc_tick), .mr(mr), .por_block(por_block),
    .por_pulse(por_pulse), .sel_a(sel_a), .sel_b(sel_b), .qsel(qsel),
    .mode(mode), .q(q)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int tap_stage(input bit a, input bit b);
    if (a) return 16;
    return b ? 10 : 13;
  endfunction

  // cycle model: ticks counted as integers, stage bit from the total
  always @(posedge clk) begin
    bit clr_m;
    int total, n;
    bit tb;
    clr_m = mr || (por_pulse && !por_block) || (mode != m_mode_prev);
    m_mode_prev = mode;
    if (clr_m) begin
      m_lo = 0; m_hi = 0; m_latch = 0; m_q = qsel;
    end else begin
      if (osc_tick) begin
        if (sel_a && !sel_b) m_hi = (m_hi + 1) % 256;
        else if (m_lo == 255) m_hi = (m_hi + 1) % 256;
        m_lo = (m_lo + 1) % 256;
      end
      total = m_hi * 256 + m_lo;
      n = tap_stage(sel_a, sel_b);
      tb = ((total >> (n - 1)) & 1) != 0;
      if (!mode && tb) m_latch = 1;
      m_q = qsel ^ (mode ? tb : m_latch);
    end
  end

  always @(negedge clk) begin
    if (armed) check("R5/R6 model", q, m_q);
  end

  // pulse mr for one edge, ticks off
  task automatic pulse_mr();
    osc_tick = 1'b0; mr = 1'b1;
    @(negedge clk);
    mr = 1'b0;
  endtask

  // tick until q differs from level; returns ticks used
  task automatic ticks_until_not(input bit level, input int gap, input int limit,
                                 output int used);
    used = 0;
    while (used < limit) begin
      osc_tick = 1'b1;
      @(negedge clk);
      used++;
      osc_tick = 1'b0;
      if (q != level) break;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    osc_tick = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      osc_tick = 1'b1; @(negedge clk);
    end
    osc_tick = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int used;
    repeat (3) @(negedge clk);
    check("R3 reset q=qsel=1", q, 1);
    qsel = 1'b0; @(negedge clk);
    check("R3 reset q=qsel=0", q, 0);
    qsel = 1'b1; @(negedge clk);
    mr = 1'b0;
    armed = 1'b1;

    // R1 stage 10 single shot
    sel_a = 0; sel_b = 1; pulse_mr();
    check("R3 q after mr", q, 1);
    ticks_until_not(1'b1, 0, 70000, used);
    check("R1 stage10 ticks", used, 512);
    // R6 stays low past counter wrap of tap
    run_ticks(1100);
    check("R6 still low", q, 0);

    // R1 stage 13
    sel_a = 0; sel_b = 0; pulse_mr();
    ticks_until_not(1'b1, 0, 70000, used);
    check("R1 stage13 ticks", used, 4096);

    // R1 stage 16
    sel_a = 1; sel_b = 1; pulse_mr();
    ticks_until_not(1'b1, 0, 70000, used);
    check("R1 stage16 ticks", used, 32768);

    // R2 shortcut single shot
    sel_a = 1; sel_b = 0; pulse_mr();
    ticks_until_not(1'b1, 0, 70000, used);
    check("R2 short ticks", used, 128);

    // R9 ticks with gaps
    sel_a = 0; sel_b = 1; pulse_mr();
    ticks_until_not(1'b1, 2, 70000, used);
    check("R9 gapped ticks", used, 512);
    repeat (5) @(negedge clk);
    check("R9 no tick hold", q, 0);

    // R7 retrigger mid run
    pulse_mr();
    run_ticks(300);
    pulse_mr();
    check("R7 q back high", q, 1);
    ticks_until_not(1'b1, 0, 70000, used);
    check("R7 full interval", used, 512);

    // R4 blocked power-on pulse mid run
    pulse_mr();
    run_ticks(200);
    por_block = 1'b1; por_pulse = 1'b1; @(negedge clk); por_pulse = 1'b0;
    ticks_until_not(1'b1, 0, 70000, used);
    check("R4 blocked por ignored", used, 312);
    // R4 enabled power-on pulse resets
    por_block = 1'b0; por_pulse = 1'b1; @(negedge clk); por_pulse = 1'b0;
    check("R4 por reset q", q, 1);
    ticks_until_not(1'b1, 0, 70000, used);
    check("R4 por restarts", used, 512);
    por_block = 1'b1;

    // R8 mode change acts as reset
    mode = 1'b1; @(negedge clk);
    check("R8 mode rise reset", q, 1);
    mode = 1'b0; @(negedge clk);
    check("R8 mode fall reset", q, 1);
    ticks_until_not(1'b1, 0, 70000, used);
    check("R8 restart after mode", used, 512);

    // R5 recycle stage 10, qsel=0
    qsel = 1'b0; mode = 1'b1; @(negedge clk);
    check("R5 recycle start", q, 0);
    run_ticks(511);
    check("R5 low half", q, 0);
    run_ticks(1);
    check("R5 rise at 512", q, 1);
    run_ticks(512);
    check("R5 fall at 1024", q, 0);

    // R5 polarity inverted, R2 shortcut recycle
    qsel = 1'b1; sel_a = 1; sel_b = 0; pulse_mr();
    check("R5 inv start", q, 1);
    ticks_until_not(1'b1, 0, 70000, used);
    check("R2 short half period", used, 128);
    ticks_until_not(1'b0, 0, 70000, used);
    check("R2 short second half", used, 128);

    done = 1'b1;
    armed = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule